// File: doc/BRIEF.md
# Ping-Pong Receive Packet Buffer

This block stores received packets for one OUT endpoint of a USB function controller in two equal banks. The packet side opens a packet with a start strobe, pushes bytes with a write strobe and closes the packet with an end strobe. The finished bank is then handed to the CPU side. The CPU sees exactly one bank at a time. It reads that bank byte by byte through a registered read port and reads its byte count from the size output. When it has finished, it pulses a release trigger. The trigger empties that bank and hands the CPU the other bank if a packet is waiting there.

With two banks, a second packet can land while software is still working through the first. Only when both banks hold unread packets does the block refuse a new packet and raise a request for the packet side to answer with NAK. Bank ownership follows two rules. A new packet goes into an empty bank, and the bank not currently selected by the CPU is tried first. The CPU selection moves only to a bank that holds a completed packet.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, cpu_size is 0, cpu_ready is 0, cpu_sel is 0 (bank 0), usb_nak_req is 0 and usb_ovf is 0.
- R2: On usb_sop, the packet is assigned to the empty bank that the CPU has not selected, or to the selected bank if that bank is the only empty one. The cycle after usb_eop, cpu_ready is 1 and cpu_sel names the bank holding the oldest unread packet.
- R3: cpu_size equals the number of bytes accepted into the selected bank and is 0 while cpu_ready is 0. A byte is accepted when usb_wr_en is high in a cycle after usb_sop, up to and including the usb_eop cycle.
- R4: A bank holds at most DEPTH (64) bytes. Further bytes of that packet are dropped, the count stays at DEPTH, and usb_ovf is 1 from the cycle after the first dropped byte until the next usb_sop.
- R5: While both banks hold unread packets, usb_nak_req is 1. A packet started in that state is refused and leaves both stored packets and their counts unchanged.
- R6: A cycle with cpu_rd_en high while a packet is selected places the byte at the read pointer on cpu_rd_data in the next cycle and advances the pointer, so bytes come out in the order they were written. cpu_rd_data holds its value in cycles without a read.
- R7: A cpu_release pulse while cpu_ready is 1 empties the selected bank and returns the read pointer to 0. Selection moves to the other bank if that bank holds a completed packet. Otherwise selection stays and cpu_ready falls.
- R8: cpu_release is a one-shot trigger with no stored state. A pulse while cpu_ready is 0 changes neither cpu_sel, cpu_ready nor cpu_size.
- R9: When cpu_release and usb_eop fall in the same cycle, both take effect. The bank freed in that cycle is not written in that cycle, and it takes the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_sop | input | 1 | Start of a received packet |
| usb_wr_en | input | 1 | Byte strobe for usb_wr_data |
| usb_wr_data | input | DW | Received byte |
| usb_eop | input | 1 | Packet complete |
| usb_nak_req | output | 1 | Both banks full, refuse packets |
| usb_ovf | output | 1 | Current packet exceeded one bank |
| cpu_rd_en | input | 1 | Read one byte from the selected bank |
| cpu_rd_data | output | DW | Byte read, valid the cycle after cpu_rd_en |
| cpu_release | input | 1 | One-shot trigger: free the selected bank |
| cpu_size | output | SZW | Byte count of the selected bank |
| cpu_ready | output | 1 | Selected bank holds a packet |
| cpu_sel | output | 1 | Index of the CPU-selected bank |

## Verification
The two functions that can land in one cycle are the CPU's release of its bank and the packet side's completion of the other bank. The bench provokes this by holding a packet in one bank and streaming a second into the other. It then raises usb_eop and cpu_release on the same clock. The result counts as correct when, on the next cycle, selection has moved to the just-completed bank with its size and ready flag shown. The following packet must then land in the bank that was freed, which the bench confirms by releasing again and reading that packet's first byte.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  typedef logic bank_t;

  function automatic bank_t other_bank(input bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/rxpp_mem.sv
module rxpp_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill
  import rxpp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sop,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  input  logic                eop,
  input  logic [1:0]          full,
  input  bank_t               sel,
  output logic                mem_we,
  output logic [PW:0]         mem_waddr,
  output logic [DW-1:0]       mem_wdata,
  output logic                done,
  output bank_t               done_bank,
  output logic [1:0][CW-1:0]  cnt,
  output logic                ovf
);
  logic  act_q;
  bank_t bank_q;
  bank_t tgt;
  logic  tgt_ok;
  logic  room;
  logic  drop;

  // choose a target bank from the stored (pre-edge) ownership state
  always_comb begin
    tgt    = other_bank(sel);
    tgt_ok = 1'b1;
    if (!full[other_bank(sel)]) tgt = other_bank(sel);
    else if (!full[sel])        tgt = sel;
    else                        tgt_ok = 1'b0;
  end

  assign room      = cnt[bank_q] < CW'(DEPTH);
  assign mem_we    = act_q & ~sop & wr_en & room;
  assign drop      = act_q & ~sop & wr_en & ~room;
  assign done      = act_q & ~sop & eop;
  assign done_bank = bank_q;
  assign mem_waddr = {bank_q, cnt[bank_q][PW-1:0]};
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      bank_q <= 1'b0;
      ovf    <= 1'b0;
      cnt    <= '0;
    end else if (sop) begin
      act_q  <= tgt_ok;
      bank_q <= tgt;
      ovf    <= 1'b0;
      if (tgt_ok) cnt[tgt] <= '0;
    end else begin
      if (mem_we) cnt[bank_q] <= cnt[bank_q] + 1'b1;
      if (drop)   ovf <= 1'b1;
      if (done)   act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxpp_own.sv
module rxpp_own
  import rxpp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        done,
  input  bank_t       done_bank,
  input  logic        release_in,
  input  logic        rd_en,
  output logic [1:0]  full,
  output bank_t       sel,
  output logic        rd_fire,
  output logic [PW:0] rd_addr,
  output logic        nak
);
  logic [1:0]    full_n;
  bank_t         sel_n;
  logic [PW-1:0] ptr_q;
  logic          rel_ok;

  assign rel_ok  = release_in & full[sel];
  assign rd_fire = rd_en & full[sel];
  assign rd_addr = {sel, ptr_q};

  always_comb begin
    full_n = full;
    if (rel_ok) full_n[sel] = 1'b0;
    if (done)   full_n[done_bank] = 1'b1;
    sel_n = sel;
    if (!full_n[sel] && full_n[other_bank(sel)]) sel_n = other_bank(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= '0;
      sel   <= 1'b0;
      ptr_q <= '0;
      nak   <= 1'b0;
    end else begin
      full <= full_n;
      sel  <= sel_n;
      nak  <= &full_n;
      if (rel_ok)
        ptr_q <= '0;
      else if (rd_fire && ptr_q != PW'(DEPTH - 1))
        ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int SZW   = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           usb_sop,
  input  logic           usb_wr_en,
  input  logic [DW-1:0]  usb_wr_data,
  input  logic           usb_eop,
  output logic           usb_nak_req,
  output logic           usb_ovf,
  input  logic           cpu_rd_en,
  output logic [DW-1:0]  cpu_rd_data,
  input  logic           cpu_release,
  output logic [SZW-1:0] cpu_size,
  output logic           cpu_ready,
  output logic           cpu_sel
);
  logic [1:0]         full;
  logic               sel;
  logic               mem_we;
  logic [PW:0]        mem_waddr;
  logic [DW-1:0]      mem_wdata;
  logic               done;
  logic               done_bank;
  logic [1:0][CW-1:0] cnt;
  logic               rd_fire;
  logic [PW:0]        rd_addr;

  rxpp_fill #(.DEPTH(DEPTH), .DW(DW)) u_fill (
    .clk(clk), .rst(rst), .sop(usb_sop), .wr_en(usb_wr_en), .wr_data(usb_wr_data),
    .eop(usb_eop), .full(full), .sel(sel), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .done(done), .done_bank(done_bank), .cnt(cnt), .ovf(usb_ovf)
  );

  rxpp_own #(.DEPTH(DEPTH)) u_own (
    .clk(clk), .rst(rst), .done(done), .done_bank(done_bank), .release_in(cpu_release),
    .rd_en(cpu_rd_en), .full(full), .sel(sel), .rd_fire(rd_fire), .rd_addr(rd_addr),
    .nak(usb_nak_req)
  );

  rxpp_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_fire), .raddr(rd_addr), .rdata(cpu_rd_data)
  );

  assign cpu_ready = full[sel];
  assign cpu_sel   = sel;
  assign cpu_size  = full[sel] ? {{(SZW-CW){1'b0}}, cnt[sel]} : '0;
endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int SZW   = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           usb_sop,
  input logic           usb_eop,
  input logic           usb_nak_req,
  input logic           usb_ovf,
  input logic           cpu_rd_en,
  input logic [DW-1:0]  cpu_rd_data,
  input logic           cpu_release,
  input logic [SZW-1:0] cpu_size,
  input logic           cpu_ready,
  input logic           cpu_sel
);
  // R4
  size_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_size <= SZW'(DEPTH));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (usb_ovf && !usb_sop) |=> usb_ovf);

  // R5
  nak_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    usb_nak_req |-> cpu_ready);

  // R7
  sel_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_release && usb_nak_req) |=> (cpu_ready && cpu_sel != $past(cpu_sel)));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_release && !cpu_ready && !usb_eop) |=> ($stable(cpu_sel) && !cpu_ready));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd_en && !$isunknown(cpu_rd_data)) |=> $stable(cpu_rd_data));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_ready) |-> $past(usb_eop));
endmodule

bind rx_pingpong_buf rxpp_chk #(.DEPTH(DEPTH), .DW(DW), .SZW(SZW)) u_chk (
  .clk(clk), .rst(rst), .usb_sop(usb_sop), .usb_eop(usb_eop), .usb_nak_req(usb_nak_req),
  .usb_ovf(usb_ovf), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
  .cpu_release(cpu_release), .cpu_size(cpu_size), .cpu_ready(cpu_ready), .cpu_sel(cpu_sel)
);

// File: tb/test_rx_pingpong_buf.sv
module test_rx_pingpong_buf;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int SZW   = 8;
  localparam int NPKT  = 6;
  localparam int LENS [NPKT] = '{1, 5, 17, 63, 64, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic usb_sop = 1'b0, usb_wr_en = 1'b0, usb_eop = 1'b0;
  logic [DW-1:0] usb_wr_data = '0;
  logic usb_nak_req, usb_ovf;
  logic cpu_rd_en = 1'b0, cpu_release = 1'b0;
  logic [DW-1:0] cpu_rd_data;
  logic [SZW-1:0] cpu_size;
  logic cpu_ready, cpu_sel;

  int n_chk = 0;
  int n_err = 0;
  logic exp_sel;

  always #10 clk = ~clk;

  rx_pingpong_buf #(.DEPTH(DEPTH), .DW(DW), .SZW(SZW)) i_rx_pingpong_buf (
    .clk(clk), .rst(rst), .usb_sop(usb_sop), .usb_wr_en(usb_wr_en),
    .usb_wr_data(usb_wr_data), .usb_eop(usb_eop), .usb_nak_req(usb_nak_req),
    .usb_ovf(usb_ovf), .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .cpu_release(cpu_release), .cpu_size(cpu_size), .cpu_ready(cpu_ready),
    .cpu_sel(cpu_sel)
  );

  function automatic logic [DW-1:0] pat(input int seed, input int k);
    return DW'(seed * 37 + k * 11 + 3);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic start_pkt(input int len, input int seed);
    usb_sop = 1'b1;
    @(negedge clk);
    usb_sop = 1'b0;
    for (int k = 0; k < len; k++) begin
      usb_wr_en = 1'b1;
      usb_wr_data = pat(seed, k);
      @(negedge clk);
    end
    usb_wr_en = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int seed);
    start_pkt(len, seed);
    usb_eop = 1'b1;
    @(negedge clk);
    usb_eop = 1'b0;
  endtask

  task automatic read_bytes(input int n, input int seed, input string req);
    for (int k = 0; k < n; k++) begin
      cpu_rd_en = 1'b1;
      @(negedge clk);
      chk(req, int'(cpu_rd_data), int'(pat(seed, k)));
    end
    cpu_rd_en = 1'b0;
  endtask

  task automatic pulse_release();
    cpu_release = 1'b1;
    @(negedge clk);
    cpu_release = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 size", int'(cpu_size), 0);
    chk("R1 ready", int'(cpu_ready), 0);
    chk("R1 sel", int'(cpu_sel), 0);
    chk("R1 nak", int'(usb_nak_req), 0);
    chk("R1 ovf", int'(usb_ovf), 0);

    // vector table: each packet lands in the non-selected bank and is read out
    exp_sel = 1'b0;
    for (int i = 0; i < NPKT; i++) begin
      send_pkt(LENS[i], i + 1);
      exp_sel = ~exp_sel;
      chk("R2 ready", int'(cpu_ready), 1);
      chk("R2 sel", int'(cpu_sel), int'(exp_sel));
      chk("R3 size", int'(cpu_size), LENS[i]);
      chk("R5 nak single", int'(usb_nak_req), 0);
      read_bytes(LENS[i], i + 1, "R6 data");
      pulse_release();
      chk("R7 ready drop", int'(cpu_ready), 0);
      chk("R7 sel stays", int'(cpu_sel), int'(exp_sel));
      chk("R3 size empty", int'(cpu_size), 0);
    end

    // R8 release while idle: two back-to-back pulses
    cpu_release = 1'b1;
    repeat (2) @(negedge clk);
    cpu_release = 1'b0;
    chk("R8 sel", int'(cpu_sel), int'(exp_sel));
    chk("R8 ready", int'(cpu_ready), 0);
    chk("R8 size", int'(cpu_size), 0);

    // R5 both banks full, third packet refused
    send_pkt(3, 20);
    chk("R2 sel first", int'(cpu_sel), 1);
    send_pkt(4, 21);
    chk("R5 nak", int'(usb_nak_req), 1);
    chk("R2 sel kept", int'(cpu_sel), 1);
    chk("R5 size kept", int'(cpu_size), 3);
    send_pkt(9, 22);
    chk("R5 size after refuse", int'(cpu_size), 3);
    chk("R5 nak after refuse", int'(usb_nak_req), 1);
    chk("R4 no ovf", int'(usb_ovf), 0);
    pulse_release();
    chk("R7 sel moves", int'(cpu_sel), 0);
    chk("R7 ready held", int'(cpu_ready), 1);
    chk("R5 other size", int'(cpu_size), 4);
    chk("R5 nak clear", int'(usb_nak_req), 0);
    read_bytes(1, 21, "R5 content");
    pulse_release();
    chk("R7 ready empty", int'(cpu_ready), 0);

    // R9 release and end-of-packet in the same cycle
    send_pkt(2, 30);
    chk("R9 setup sel", int'(cpu_sel), 1);
    start_pkt(5, 31);
    usb_eop = 1'b1;
    cpu_release = 1'b1;
    @(negedge clk);
    usb_eop = 1'b0;
    cpu_release = 1'b0;
    chk("R9 sel", int'(cpu_sel), 0);
    chk("R9 ready", int'(cpu_ready), 1);
    chk("R9 size", int'(cpu_size), 5);
    chk("R9 nak", int'(usb_nak_req), 0);
    send_pkt(6, 32);
    chk("R9 freed bank reused nak", int'(usb_nak_req), 1);
    chk("R9 size kept", int'(cpu_size), 5);
    read_bytes(2, 31, "R9 data");
    pulse_release();
    chk("R9 next sel", int'(cpu_sel), 1);
    chk("R9 next size", int'(cpu_size), 6);
    read_bytes(1, 32, "R7 ptr reset");
    pulse_release();
    chk("R7 ready after", int'(cpu_ready), 0);

    // R4 overflow: 70 bytes into a 64-byte bank
    send_pkt(70, 40);
    chk("R4 size sat", int'(cpu_size), DEPTH);
    chk("R4 ovf", int'(usb_ovf), 1);
    chk("R2 sel ovf", int'(cpu_sel), 0);
    read_bytes(DEPTH, 40, "R4 data");
    pulse_release();
    send_pkt(1, 41);
    chk("R4 ovf cleared", int'(usb_ovf), 0);
    chk("R3 size one", int'(cpu_size), 1);
    read_bytes(1, 41, "R6 single");
    pulse_release();
    chk("R7 final ready", int'(cpu_ready), 0);

    @(negedge clk);
    finish_run();
  end
endmodule